// File: doc/BRIEF.md
# Gamma Table Register Bank

This block is the memory-mapped control face of a gamma correction pipeline. A processor reaches it over an AXI4-Lite slave port. It keeps a control word with start, done, idle, ready and auto-restart flags, the active frame width and height, and a colour format selector. It also holds three lookup tables, one for each colour channel. Each table is reached through its own address window, where every 32-bit word carries two adjacent table entries.

On the pipeline side the bank drives the start request, the auto-restart flag, the frame size and the format. On each table write it pulses a one-hot channel strobe together with the entry-pair index and the two stored entries, so that the pipeline can update its own working copy. The pipeline sends back three status inputs: a done pulse, an idle level and a ready level. The ready level also serves as the handshake that consumes a start request. One clock drives the block. Its reset is synchronous and active-low.

Top module: `gamma_table_regs`

## Requirements
- R1: After reset every readable location returns zero, the start request, auto-restart, size and format outputs are zero, bValid and rValid are low, and no table strobe is active.
- R2: Active width is read and written at byte offset 0x10 and active height at 0x18, each DIM_W bits wide with higher bits reading zero. The format flag is bit 0 at 0x20, where 0 selects RGB and 1 selects YUV 4:4:4. The stored values drive activeWidth, activeHeight and videoFmt.
- R3: At offset 0x00, bit 0 is the start request and bit 7 is auto-restart. Both are writable. The done bit (bit 1) cannot be written, and reserved bits read zero.
- R4: A set start bit clears on a cycle in which pipeReady is high, unless auto-restart is set. In that case it stays set.
- R5: A pipeDone pulse sets control bit 1. This bit stays set until the control word is read, that read returns it as 1, and a following read returns 0.
- R6: Control bit 2 reads the current pipeIdle level, and control bit 3 reads the current pipeReady level.
- R7: The red, green and blue tables occupy the windows at 0x800, 0x1000 and 0x1800. Word n of a window holds entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. Only the low ENT_W bits of each half are kept, and reads return them zero-extended.
- R8: Byte strobe wStrb[k] enables byte lane k on every write. Lanes whose strobe is low leave the stored bits unchanged, in the size registers and in the tables alike.
- R9: A table write raises the matching bit of tblWe (bit 0 red, 1 green, 2 blue) for one cycle, together with the pair index n and the two stored entries. At most one bit of tblWe is ever high.
- R10: The write address and write data may arrive in either order or together. Exactly one OKAY (00) response follows once both have been taken, and bValid holds until bReady.
- R11: Offsets 0x04, 0x08, 0x0C and other unmapped offsets, including table words beyond the table depth, read zero. Writes to them complete with OKAY and change nothing. The irq output stays low.
- R12: A read completes with rResp OKAY. rValid and rData hold until rReady, and arReady stays low while a read response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the pipeline side |
| rstN | input | 1 | Synchronous reset, active low |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| awAddr | input | 13 | Write byte address |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| wData | input | 32 | Write data |
| wStrb | input | 4 | Write byte strobes |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| bResp | output | 2 | Write response code |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| arAddr | input | 13 | Read byte address |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response code |
| irq | output | 1 | Interrupt request, held low |
| pipeDone | input | 1 | Frame-finished pulse from the pipeline |
| pipeIdle | input | 1 | Pipeline idle level |
| pipeReady | input | 1 | Pipeline ready level, consumes a start request |
| startReq | output | 1 | Start request to the pipeline |
| autoRestart | output | 1 | Free-running mode flag |
| activeWidth | output | DIM_W | Active pixels per line |
| activeHeight | output | DIM_W | Active lines per frame |
| videoFmt | output | 1 | 0 RGB, 1 YUV 4:4:4 |
| tblWe | output | 3 | One-hot table write strobe |
| tblPair | output | ENT_W-1 | Entry-pair index of the write |
| tblLo | output | ENT_W | Stored even entry |
| tblHi | output | ENT_W | Stored odd entry |

## Verification
The assertions on the bus channels assume that the manager keeps awValid and wValid high until their handshake, and does not change the address, data or strobes in the meantime. The stimulus holds every valid and payload steady from one falling edge until the handshake edge. It assigns new values only at falling edges, and it drops each valid right after the handshake. The start-handshake checks assume that pipeReady only changes while no control write is in flight. The bench sets pipeDone, pipeIdle and pipeReady between bus transactions.

// File: rtl/gamma_regs_pkg.sv
package gamma_regs_pkg;

  localparam int ADDR_W = 13;
  localparam int BUS_W  = 32;
  localparam int STRB_W = BUS_W / 8;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // address bits [12:11] select the space: registers or one of three tables
  typedef enum logic [1:0] {
    SPACE_REGS  = 2'd0,
    SPACE_RED   = 2'd1,
    SPACE_GREEN = 2'd2,
    SPACE_BLUE  = 2'd3
  } space_e;

  localparam logic [10:0] OFS_CTRL   = 11'h000;
  localparam logic [10:0] OFS_WIDTH  = 11'h010;
  localparam logic [10:0] OFS_HEIGHT = 11'h018;
  localparam logic [10:0] OFS_FMT    = 11'h020;

  // strobes from the bus control to the register file
  typedef struct packed {
    logic              wrGo;
    logic [ADDR_W-1:0] wrAddr;
    logic [BUS_W-1:0]  wrData;
    logic [STRB_W-1:0] wrStrb;
    logic              rdGo;
    logic [ADDR_W-1:0] rdAddr;
  } busCmd_t;

  function automatic logic [BUS_W-1:0] mergeBytes(input logic [BUS_W-1:0] oldWord,
                                                  input logic [BUS_W-1:0] newWord,
                                                  input logic [STRB_W-1:0] strb);
    logic [BUS_W-1:0] res;
    for (int b = 0; b < STRB_W; b++)
      res[8*b +: 8] = strb[b] ? newWord[8*b +: 8] : oldWord[8*b +: 8];
    return res;
  endfunction

endpackage

// File: rtl/gamma_bus_ctrl.sv
module gamma_bus_ctrl
  import gamma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              awValid,
  output logic              awReady,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              wValid,
  output logic              wReady,
  input  logic [BUS_W-1:0]  wData,
  input  logic [STRB_W-1:0] wStrb,
  output logic              bValid,
  input  logic              bReady,
  output logic [1:0]        bResp,
  input  logic              arValid,
  output logic              arReady,
  input  logic [ADDR_W-1:0] arAddr,
  output logic              rValid,
  input  logic              rReady,
  output logic [BUS_W-1:0]  rData,
  output logic [1:0]        rResp,
  output busCmd_t           cmd,
  input  logic [BUS_W-1:0]  rdWord
);

  logic              awHeld, wHeld;
  logic [ADDR_W-1:0] awAddrQ;
  logic [BUS_W-1:0]  wDataQ;
  logic [STRB_W-1:0] wStrbQ;
  logic              commit, rdTake;

  assign awReady = !awHeld;
  assign wReady  = !wHeld;
  assign arReady = !rValid;
  assign commit  = awHeld && wHeld && !bValid;
  assign rdTake  = arValid && arReady;
  assign bResp   = RESP_OKAY;
  assign rResp   = RESP_OKAY;

  always_comb begin
    cmd        = '0;
    cmd.wrGo   = commit;
    cmd.wrAddr = awAddrQ;
    cmd.wrData = wDataQ;
    cmd.wrStrb = wStrbQ;
    cmd.rdGo   = rdTake;
    cmd.rdAddr = arAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awHeld  <= 1'b0;
      wHeld   <= 1'b0;
      awAddrQ <= '0;
      wDataQ  <= '0;
      wStrbQ  <= '0;
      bValid  <= 1'b0;
    end else begin
      if (awValid && awReady) begin
        awHeld  <= 1'b1;
        awAddrQ <= awAddr;
      end
      if (wValid && wReady) begin
        wHeld  <= 1'b1;
        wDataQ <= wData;
        wStrbQ <= wStrb;
      end
      if (commit) begin
        awHeld <= 1'b0;
        wHeld  <= 1'b0;
        bValid <= 1'b1;
      end else if (bValid && bReady) begin
        bValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValid <= 1'b0;
      rData  <= '0;
    end else if (rdTake) begin
      rValid <= 1'b1;
      rData  <= rdWord;
    end else if (rValid && rReady) begin
      rValid <= 1'b0;
    end
  end

  a_r10_bvalid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> bValid);
  a_r10_one_response: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && bReady) |=> !bValid);
  a_r12_rvalid_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData)));
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    rValid |-> !arReady);

endmodule

// File: rtl/gamma_reg_file.sv
module gamma_reg_file
  import gamma_regs_pkg::*;
#(
  parameter int ENT_W = 8,   // entry width, 2..10 so a table fits its window
  parameter int DIM_W = 16,
  localparam int PAIR_W = ENT_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  output logic [BUS_W-1:0]  rdWord,
  input  logic              pipeDone,
  input  logic              pipeIdle,
  input  logic              pipeReady,
  output logic              startReq,
  output logic              autoRestart,
  output logic [DIM_W-1:0]  activeWidth,
  output logic [DIM_W-1:0]  activeHeight,
  output logic              videoFmt,
  output logic [2:0]        tblWe,
  output logic [PAIR_W-1:0] tblPair,
  output logic [ENT_W-1:0]  tblLo,
  output logic [ENT_W-1:0]  tblHi
);

  localparam int DEPTH = 1 << ENT_W;
  localparam int PAIRS = DEPTH / 2;
  localparam int NCHAN = 3;

  space_e            wrSpace, rdSpace;
  logic [10:0]       wrOfs, rdOfs;
  logic [8:0]        wrWordIdx, rdWordIdx;
  logic              wrInTbl, rdInTbl;
  logic [PAIR_W-1:0] wrPair, rdPair;
  logic [1:0]        wrChan, rdChan;
  logic              ctrlWr, ctrlRd, widthWr, heightWr, fmtWr;
  logic              doneBit;
  logic [BUS_W-1:0]  widthNext, heightNext, oldSel, mergedPair;
  logic [ENT_W-1:0]  newLo, newHi;
  logic [BUS_W-1:0]  oldPairWord [NCHAN];
  logic [BUS_W-1:0]  rdPairWord  [NCHAN];
  logic [NCHAN-1:0]  tblHit;

  // address decode
  assign wrSpace   = space_e'(cmd.wrAddr[12:11]);
  assign rdSpace   = space_e'(cmd.rdAddr[12:11]);
  assign wrOfs     = {cmd.wrAddr[10:2], 2'b00};
  assign rdOfs     = {cmd.rdAddr[10:2], 2'b00};
  assign wrWordIdx = cmd.wrAddr[10:2];
  assign rdWordIdx = cmd.rdAddr[10:2];
  assign wrInTbl   = 32'(wrWordIdx) < PAIRS;
  assign rdInTbl   = 32'(rdWordIdx) < PAIRS;
  assign wrPair    = wrWordIdx[PAIR_W-1:0];
  assign rdPair    = rdWordIdx[PAIR_W-1:0];
  assign wrChan    = cmd.wrAddr[12:11] - 2'd1;
  assign rdChan    = cmd.rdAddr[12:11] - 2'd1;

  assign ctrlWr   = cmd.wrGo && (wrSpace == SPACE_REGS) && (wrOfs == OFS_CTRL);
  assign widthWr  = cmd.wrGo && (wrSpace == SPACE_REGS) && (wrOfs == OFS_WIDTH);
  assign heightWr = cmd.wrGo && (wrSpace == SPACE_REGS) && (wrOfs == OFS_HEIGHT);
  assign fmtWr    = cmd.wrGo && (wrSpace == SPACE_REGS) && (wrOfs == OFS_FMT);
  assign ctrlRd   = cmd.rdGo && (rdSpace == SPACE_REGS) && (rdOfs == OFS_CTRL);

  assign widthNext  = mergeBytes(BUS_W'(activeWidth), cmd.wrData, cmd.wrStrb);
  assign heightNext = mergeBytes(BUS_W'(activeHeight), cmd.wrData, cmd.wrStrb);

  // control and size registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReq     <= 1'b0;
      autoRestart  <= 1'b0;
      doneBit      <= 1'b0;
      activeWidth  <= '0;
      activeHeight <= '0;
      videoFmt     <= 1'b0;
    end else begin
      if (ctrlWr && cmd.wrStrb[0]) begin
        startReq    <= cmd.wrData[0];
        autoRestart <= cmd.wrData[7];
      end else if (startReq && pipeReady && !autoRestart) begin
        startReq <= 1'b0;
      end
      if (pipeDone)    doneBit <= 1'b1;
      else if (ctrlRd) doneBit <= 1'b0;
      if (widthWr)  activeWidth  <= widthNext[DIM_W-1:0];
      if (heightWr) activeHeight <= heightNext[DIM_W-1:0];
      if (fmtWr && cmd.wrStrb[0]) videoFmt <= cmd.wrData[0];
    end
  end

  // the three lookup tables
  for (genvar c = 0; c < NCHAN; c++) begin : g_tbl
    logic [ENT_W-1:0] mem [DEPTH];
    assign tblHit[c] = cmd.wrGo && (wrSpace == space_e'(c + 1)) && wrInTbl;
    assign oldPairWord[c] = {16'(mem[{wrPair, 1'b1}]), 16'(mem[{wrPair, 1'b0}])};
    assign rdPairWord[c]  = {16'(mem[{rdPair, 1'b1}]), 16'(mem[{rdPair, 1'b0}])};
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (tblHit[c]) begin
        mem[{wrPair, 1'b0}] <= newLo;
        mem[{wrPair, 1'b1}] <= newHi;
      end
    end
  end

  assign oldSel     = (wrSpace == SPACE_REGS) ? '0 : oldPairWord[wrChan];
  assign mergedPair = mergeBytes(oldSel, cmd.wrData, cmd.wrStrb);
  assign newLo      = mergedPair[ENT_W-1:0];
  assign newHi      = mergedPair[16 +: ENT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblWe   <= '0;
      tblPair <= '0;
      tblLo   <= '0;
      tblHi   <= '0;
    end else begin
      tblWe <= tblHit;
      if (|tblHit) begin
        tblPair <= wrPair;
        tblLo   <= newLo;
        tblHi   <= newHi;
      end
    end
  end

  // read mux
  always_comb begin
    rdWord = '0;
    if (rdSpace == SPACE_REGS) begin
      case (rdOfs)
        OFS_CTRL:   rdWord = {24'b0, autoRestart, 3'b000, pipeReady, pipeIdle, doneBit, startReq};
        OFS_WIDTH:  rdWord = BUS_W'(activeWidth);
        OFS_HEIGHT: rdWord = BUS_W'(activeHeight);
        OFS_FMT:    rdWord = BUS_W'(videoFmt);
        default:    rdWord = '0;
      endcase
    end else if (rdInTbl) begin
      rdWord = rdPairWord[rdChan];
    end
  end

  a_r4_start_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && pipeReady && !autoRestart && !ctrlWr) |=> !startReq);
  a_r4_start_kept_auto: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && autoRestart && !ctrlWr) |=> startReq);
  a_r5_done_capture: assert property (@(posedge clk) disable iff (!rstN)
    pipeDone |=> doneBit);
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneBit && !ctrlRd) |=> doneBit);
  a_r9_one_table: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tblWe));
  a_r11_reserved_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrGo && (wrSpace == SPACE_REGS) && !ctrlWr && !widthWr && !heightWr && !fmtWr)
    |=> ($stable(activeWidth) && $stable(activeHeight) && $stable(videoFmt)
         && $stable(autoRestart) && (tblWe == '0)));

endmodule

// File: rtl/gamma_table_regs.sv
module gamma_table_regs
  import gamma_regs_pkg::*;
#(
  parameter int ENT_W = 8,
  parameter int DIM_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              awValid,
  output logic              awReady,
  input  logic [12:0]       awAddr,
  input  logic              wValid,
  output logic              wReady,
  input  logic [31:0]       wData,
  input  logic [3:0]        wStrb,
  output logic              bValid,
  input  logic              bReady,
  output logic [1:0]        bResp,
  input  logic              arValid,
  output logic              arReady,
  input  logic [12:0]       arAddr,
  output logic              rValid,
  input  logic              rReady,
  output logic [31:0]       rData,
  output logic [1:0]        rResp,
  output logic              irq,
  input  logic              pipeDone,
  input  logic              pipeIdle,
  input  logic              pipeReady,
  output logic              startReq,
  output logic              autoRestart,
  output logic [DIM_W-1:0]  activeWidth,
  output logic [DIM_W-1:0]  activeHeight,
  output logic              videoFmt,
  output logic [2:0]        tblWe,
  output logic [ENT_W-2:0]  tblPair,
  output logic [ENT_W-1:0]  tblLo,
  output logic [ENT_W-1:0]  tblHi
);

  busCmd_t          cmd;
  logic [BUS_W-1:0] rdWord;

  assign irq = 1'b0;

  gamma_bus_ctrl u_bus (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp),
    .cmd(cmd), .rdWord(rdWord)
  );

  gamma_reg_file #(.ENT_W(ENT_W), .DIM_W(DIM_W)) u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rdWord(rdWord),
    .pipeDone(pipeDone), .pipeIdle(pipeIdle), .pipeReady(pipeReady),
    .startReq(startReq), .autoRestart(autoRestart),
    .activeWidth(activeWidth), .activeHeight(activeHeight), .videoFmt(videoFmt),
    .tblWe(tblWe), .tblPair(tblPair), .tblLo(tblLo), .tblHi(tblHi)
  );

endmodule

// File: tb/gamma_table_regs_test.sv
module gamma_table_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int ENT_W = 8;
  localparam int DIM_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic awValid = 0, wValid = 0, bReady = 0, arValid = 0, rReady = 0;
  logic [12:0] awAddr = '0, arAddr = '0;
  logic [31:0] wData = '0;
  logic [3:0]  wStrb = '0;
  logic pipeDone = 0, pipeIdle = 0, pipeReady = 0;
  logic awReady, wReady, bValid, arReady, rValid, irq;
  logic [1:0] bResp, rResp;
  logic [31:0] rData;
  logic startReq, autoRestart, videoFmt;
  logic [DIM_W-1:0] activeWidth, activeHeight;
  logic [2:0] tblWe;
  logic [ENT_W-2:0] tblPair;
  logic [ENT_W-1:0] tblLo, tblHi;

  int total = 0;
  int bad = 0;
  int weCount = 0;
  logic [2:0] lastWe = '0;
  logic [ENT_W-2:0] lastPair = '0;
  logic [ENT_W-1:0] lastLo = '0, lastHi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_table_regs #(.ENT_W(ENT_W), .DIM_W(DIM_W)) uut (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb),
    .bValid(bValid), .bReady(bReady), .bResp(bResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp),
    .irq(irq), .pipeDone(pipeDone), .pipeIdle(pipeIdle), .pipeReady(pipeReady),
    .startReq(startReq), .autoRestart(autoRestart),
    .activeWidth(activeWidth), .activeHeight(activeHeight), .videoFmt(videoFmt),
    .tblWe(tblWe), .tblPair(tblPair), .tblLo(tblLo), .tblHi(tblHi)
  );

  // record table strobes away from the active edge
  always @(negedge clk) begin
    if (tblWe != 3'b000) begin
      weCount++;
      lastWe   = tblWe;
      lastPair = tblPair;
      lastLo   = tblLo;
      lastHi   = tblHi;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic axiWrite(input logic [12:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int awDly, input int wDly, input int bDly);
    bit awDone = 0;
    bit wDone = 0;
    bit aRdy, dRdy;
    int cyc = 0;
    while (!(awDone && wDone)) begin
      if (!awDone && cyc >= awDly) begin awValid = 1; awAddr = a; end
      if (!wDone && cyc >= wDly) begin wValid = 1; wData = d; wStrb = s; end
      aRdy = awReady;
      dRdy = wReady;
      @(posedge clk);
      if (awValid && aRdy) awDone = 1;
      if (wValid && dRdy) wDone = 1;
      @(negedge clk);
      if (awDone) awValid = 0;
      if (wDone) wValid = 0;
      cyc++;
    end
    while (!bValid) @(negedge clk);
    for (int i = 0; i < bDly; i++) begin
      @(negedge clk);
      check("R10 bValid held without bReady", 32'(bValid), 32'd1);
    end
    check("R10 bResp OKAY", 32'(bResp), 32'd0);
    bReady = 1;
    @(posedge clk);
    @(negedge clk);
    bReady = 0;
    check("R10 single response", 32'(bValid), 32'd0);
  endtask

  task automatic axiRead(input logic [12:0] a, input int rDly, output logic [31:0] d);
    bit done = 0;
    bit rdy;
    logic [31:0] first;
    arValid = 1;
    arAddr = a;
    while (!done) begin
      rdy = arReady;
      @(posedge clk);
      if (rdy) done = 1;
      @(negedge clk);
    end
    arValid = 0;
    while (!rValid) @(negedge clk);
    first = rData;
    for (int i = 0; i < rDly; i++) begin
      @(negedge clk);
      check("R12 rValid held", 32'(rValid), 32'd1);
      check("R12 rData stable", rData, first);
      check("R12 arReady low while pending", 32'(arReady), 32'd0);
    end
    check("R12 rResp OKAY", 32'(rResp), 32'd0);
    d = rData;
    rReady = 1;
    @(posedge clk);
    @(negedge clk);
    rReady = 0;
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    axiWrite(a, d, 4'hF, 0, 0, 0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 startReq", 32'(startReq), 0);
    check("R1 autoRestart", 32'(autoRestart), 0);
    check("R1 width out", 32'(activeWidth), 0);
    check("R1 height out", 32'(activeHeight), 0);
    check("R1 format out", 32'(videoFmt), 0);
    check("R1 bValid/rValid", {30'b0, bValid, rValid}, 0);
    check("R1 tblWe", 32'(tblWe), 0);
    axiRead(13'h000, 0, v); check("R1 ctrl read", v, 0);
    axiRead(13'h010, 0, v); check("R1 width read", v, 0);
    axiRead(13'h018, 0, v); check("R1 height read", v, 0);
    axiRead(13'h020, 0, v); check("R1 format read", v, 0);
    axiRead(13'h1004, 0, v); check("R1 table read", v, 0);
  endtask

  task automatic testGeometry();
    logic [31:0] v;
    wr(13'h010, 32'h0000_0780);
    wr(13'h018, 32'h0000_0438);
    wr(13'h020, 32'h0000_0001);
    axiRead(13'h010, 0, v); check("R2 width read", v, 32'h780);
    axiRead(13'h018, 0, v); check("R2 height read", v, 32'h438);
    axiRead(13'h020, 0, v); check("R2 format YUV", v, 32'h1);
    check("R2 width out", 32'(activeWidth), 32'h780);
    check("R2 height out", 32'(activeHeight), 32'h438);
    check("R2 format out", 32'(videoFmt), 1);
    wr(13'h010, 32'hABCD_1234);
    axiRead(13'h010, 0, v); check("R2 width upper zero", v, 32'h1234);
    wr(13'h020, 32'h0000_0002);
    axiRead(13'h020, 0, v); check("R2 format RGB", v, 32'h0);
  endtask

  task automatic testStrobes();
    logic [31:0] v;
    wr(13'h010, 32'h0000_FFFF);
    axiWrite(13'h010, 32'h0000_0078, 4'b0001, 0, 0, 0);
    axiRead(13'h010, 0, v); check("R8 width lane 0 only", v, 32'hFF78);
    wr(13'h080C, 32'hAABB_CCDD);
    axiRead(13'h080C, 0, v); check("R8 table full word", v, 32'h00BB_00DD);
    axiWrite(13'h080C, 32'h1122_3344, 4'b0100, 0, 0, 0);
    axiRead(13'h080C, 0, v); check("R8 table lane 2 only", v, 32'h0022_00DD);
  endtask

  task automatic testControl();
    logic [31:0] v;
    wr(13'h000, 32'hFFFF_FFFF);
    axiRead(13'h000, 0, v); check("R3 ctrl writable bits", v, 32'h81);
    check("R3 startReq out", 32'(startReq), 1);
    check("R3 autoRestart out", 32'(autoRestart), 1);
    wr(13'h000, 32'h0);
    axiRead(13'h000, 0, v); check("R3 ctrl cleared", v, 32'h0);
  endtask

  task automatic testHandshake();
    wr(13'h000, 32'h1);
    check("R4 start set", 32'(startReq), 1);
    pipeReady = 1;
    @(negedge clk);
    pipeReady = 0;
    check("R4 start consumed", 32'(startReq), 0);
    wr(13'h000, 32'h81);
    pipeReady = 1;
    repeat (2) @(negedge clk);
    pipeReady = 0;
    check("R4 start kept with auto-restart", 32'(startReq), 1);
    wr(13'h000, 32'h0);
    check("R4 start cleared by write", 32'(startReq), 0);
  endtask

  task automatic testDone();
    logic [31:0] v;
    pipeDone = 1;
    @(negedge clk);
    pipeDone = 0;
    repeat (3) @(negedge clk);
    axiRead(13'h000, 0, v); check("R5 done read as set", v, 32'h2);
    axiRead(13'h000, 0, v); check("R5 done cleared by read", v, 32'h0);
  endtask

  task automatic testStatus();
    logic [31:0] v;
    pipeIdle = 1;
    axiRead(13'h000, 0, v); check("R6 idle bit", v, 32'h4);
    pipeIdle = 0;
    pipeReady = 1;
    axiRead(13'h000, 0, v); check("R6 ready bit", v, 32'h8);
    pipeReady = 0;
    axiRead(13'h000, 0, v); check("R6 both low", v, 32'h0);
  endtask

  task automatic testTables();
    logic [31:0] v;
    int n0;
    n0 = weCount;
    wr(13'h0800, 32'h0034_0012);
    check("R9 red strobe", 32'(lastWe), 32'b001);
    check("R9 pair index", 32'(lastPair), 0);
    check("R9 entries", {16'(lastHi), 16'(lastLo)}, 32'h0034_0012);
    wr(13'h1014, 32'h00FF_0080);
    check("R9 green strobe", 32'(lastWe), 32'b010);
    check("R9 green pair", 32'(lastPair), 5);
    wr(13'h19FC, 32'h0001_0002);
    check("R9 blue strobe", 32'(lastWe), 32'b100);
    check("R9 last pair", 32'(lastPair), 127);
    check("R9 one pulse per write", 32'(weCount - n0), 3);
    axiRead(13'h0800, 0, v); check("R7 red word 0", v, 32'h0034_0012);
    axiRead(13'h1014, 0, v); check("R7 green word 5", v, 32'h00FF_0080);
    axiRead(13'h19FC, 0, v); check("R7 blue last word", v, 32'h0001_0002);
    axiRead(13'h0814, 0, v); check("R7 red word 5 untouched", v, 32'h0);
    wr(13'h0804, 32'hAB12_CD34);
    axiRead(13'h0804, 0, v); check("R7 low bits zero-extended", v, 32'h0012_0034);
  endtask

  task automatic testChannels();
    logic [31:0] v;
    axiWrite(13'h0818, 32'h0011_0022, 4'hF, 3, 0, 0);
    axiRead(13'h0818, 0, v); check("R10 data before address", v, 32'h0011_0022);
    axiWrite(13'h081C, 32'h0033_0044, 4'hF, 0, 3, 4);
    axiRead(13'h081C, 0, v); check("R10 address before data", v, 32'h0033_0044);
  endtask

  task automatic testReads();
    logic [31:0] v;
    axiRead(13'h0818, 4, v); check("R12 delayed accept data", v, 32'h0011_0022);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    int n0;
    n0 = weCount;
    wr(13'h004, 32'hFFFF_FFFF);
    wr(13'h008, 32'hFFFF_FFFF);
    wr(13'h00C, 32'hFFFF_FFFF);
    wr(13'h01C, 32'hFFFF_FFFF);
    wr(13'h0A00, 32'hFFFF_FFFF);
    axiRead(13'h004, 0, v); check("R11 0x04 reads zero", v, 0);
    axiRead(13'h008, 0, v); check("R11 0x08 reads zero", v, 0);
    axiRead(13'h00C, 0, v); check("R11 0x0C reads zero", v, 0);
    axiRead(13'h0A00, 0, v); check("R11 beyond table reads zero", v, 0);
    axiRead(13'h0010, 0, v); check("R11 width unchanged", v, 32'hFF78);
    axiRead(13'h0018, 0, v); check("R11 height unchanged", v, 32'h438);
    axiRead(13'h0000, 0, v); check("R11 ctrl unchanged", v, 0);
    check("R11 no table strobe", 32'(weCount - n0), 0);
    check("R11 irq low", 32'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (16) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testGeometry();
    testStrobes();
    testControl();
    testHandshake();
    testDone();
    testStatus();
    testTables();
    testChannels();
    testReads();
    testUnmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule